// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog. Software arms it through a small register file, then has to keep restarting it. If software stops restarting it, the counter runs out. The block then either raises a one-cycle system-reset request or latches an interrupt flag, depending on the chosen expiry action. Two guards protect the block against stray writes. The configuration and mode registers accept a write only when the write carries a fixed key in its upper halfword. A restart happens only when the control register is written with one exact pattern.

Time is counted in half-second steps. A prescaler divides the clock by `TICK_DIV` to make one step. A 4-bit timeout code selects the period. The codes step one second at a time for short periods and two seconds at a time for long ones, up to a ceiling of sixteen seconds. The counter reloads when the watchdog is enabled, when the timeout code changes, when a valid restart arrives and when it expires. While the watchdog stays enabled, expiries therefore repeat at the programmed period.

Top module: `keyed_wdog`

## Requirements
- R1: A write to offset 0x10 whose bits [12:0] equal 0x14AF restarts the counter. Bit 0 is set and bits [12:1] hold 0xA57. The next expiry then comes a full period after that write.
- R2: A write to offset 0x10 whose bits [12:0] differ from 0x14AF does not reload the counter. The expiry keeps its earlier schedule.
- R3: Writes to offset 0x14 (configuration) and offset 0x18 (mode) take effect only when bits [31:16] equal 0x16AA. Any other value leaves the register unchanged.
- R4: Reads return the following. Mode (0x18) gives the enable bit in bit 0 and the timeout code in bits [7:4]. Configuration (0x14) gives the action in bits [1:0] and the interrupt status in bit 8. Control reads as zero. Bits [31:16] and all other bits read as zero.
- R5: The period, in seconds, follows from the timeout code as shown below. One half-second is `TICK_DIV` clock cycles. An expiry comes exactly period × 2 × `TICK_DIV` cycles after the reload.

  | Timeout code | Period |
  |---|---|
  | 0x0 | 0.5 s |
  | 0x1 to 0x6 | 1 to 6 s |
  | 0x7 | 8 s |
  | 0x8 | 10 s |
  | 0x9 | 12 s |
  | 0xA | 14 s |
  | 0xB to 0xF | 16 s |

- R6: The counter reloads with the newly decoded period in two cases: a keyed mode write that enables a stopped watchdog, and a keyed mode write that changes the timeout code while enabled.
- R7: With action 01, each expiry asserts `sys_rst_req` for exactly one cycle. The counter then reloads, and expiries repeat every period while the watchdog stays enabled.
- R8: With action 10, an expiry sets a sticky status bit that drives `wdt_irq`, and `sys_rst_req` stays low. A keyed configuration write with bit 8 set clears the status bit.
- R9: A keyed mode write with bits [15:0] zero stops the watchdog. No expiry follows.
- R10: After reset the watchdog is disabled, the action is 00, the status bit is clear and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_req | output | 1 | One-cycle system-reset request on expiry with action 01 |
| wdt_irq | output | 1 | Sticky expiry interrupt for action 10 |

## Verification
The period decode is checked with directed codes at the edges of each band: 0x0, 0x7, 0xB and 0xF. Randomly chosen codes are added to these. For each code the bench measures the cycle distance to the first expiry and to the repeat expiry, which separates a wrong decode from a wrong reload. Restart writes are tried with the exact pattern and with near-miss patterns. The expiry time then shows whether the counter was reloaded. Unkeyed writes to both keyed registers, a code change while running, a stop write and the interrupt action are each followed by readback and by watching the outputs. This separates "ignored" from "applied".

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam logic [15:0] WD_KEY        = 16'h16AA;
  localparam logic [11:0] RESTART_MAGIC = 12'hA57;
  localparam logic [7:0]  OFS_CTRL      = 8'h10;
  localparam logic [7:0]  OFS_CFG       = 8'h14;
  localparam logic [7:0]  OFS_MODE      = 8'h18;
  localparam int          HALVES_W      = 6;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_SYSRST = 2'b01,
    ACT_IRQ    = 2'b10,
    ACT_RSVD   = 2'b11
  } wd_action_e;

  // Timeout code -> period expressed in half-second steps.
  function automatic logic [HALVES_W-1:0] code_to_halves(input logic [3:0] code);
    logic [HALVES_W-1:0] c6;
    c6 = HALVES_W'(code);
    if (code == 4'h0)       return HALVES_W'(1);
    else if (code <= 4'h6)  return c6 << 1;
    else if (code <= 4'hB)  return HALVES_W'(16) + ((c6 - HALVES_W'(7)) << 2);
    else                    return HALVES_W'(32);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_set,
  output logic              mode_en,
  output logic [3:0]        mode_code,
  output wd_action_e        act,
  output logic              irq_status,
  output logic              reload,
  output logic [3:0]        load_code
);
  logic key_ok, sel_ctrl, sel_cfg, sel_mode;
  logic cfg_wr, mode_wr, restart_hit;
  logic unused_bits;

  assign key_ok      = (bus_wdata[31:16] == WD_KEY);
  assign sel_ctrl    = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cfg     = (bus_addr == ADDR_W'(OFS_CFG));
  assign sel_mode    = (bus_addr == ADDR_W'(OFS_MODE));
  assign cfg_wr      = bus_wr && sel_cfg && key_ok;
  assign mode_wr     = bus_wr && sel_mode && key_ok;
  assign restart_hit = bus_wr && sel_ctrl && (bus_wdata[12:0] == {RESTART_MAGIC, 1'b1});
  assign unused_bits = ^bus_wdata[15:13];

  // Reload on restart, on enabling, or on a code change.
  assign reload    = restart_hit ||
                     (mode_wr && bus_wdata[0] && (!mode_en || (bus_wdata[7:4] != mode_code)));
  assign load_code = mode_wr ? bus_wdata[7:4] : mode_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en    <= 1'b0;
      mode_code  <= 4'h0;
      act        <= ACT_NONE;
      irq_status <= 1'b0;
    end else begin
      if (mode_wr) begin
        mode_en   <= bus_wdata[0];
        mode_code <= bus_wdata[7:4];
      end
      if (cfg_wr) act <= wd_action_e'(bus_wdata[1:0]);
      if (irq_set)                     irq_status <= 1'b1;
      else if (cfg_wr && bus_wdata[8]) irq_status <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cfg) begin
      bus_rdata[1:0] = act;
      bus_rdata[8]   = irq_status;
    end else if (sel_mode) begin
      bus_rdata[0]   = mode_en;
      bus_rdata[7:4] = mode_code;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       reload,
  input  logic [3:0] load_code,
  output logic       expire
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0]    pre;
  logic [HALVES_W-1:0] remain;
  logic                tick;

  assign tick   = enable && (pre == PRE_W'(TICK_DIV - 1));
  assign expire = tick && !reload && (remain == HALVES_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      remain <= '0;
    end else if (reload) begin
      pre    <= '0;
      remain <= code_to_halves(load_code);
    end else if (!enable) begin
      pre    <= '0;
    end else begin
      pre <= tick ? '0 : pre + PRE_W'(1);
      if (tick)
        remain <= (remain == HALVES_W'(1)) ? code_to_halves(load_code) : remain - HALVES_W'(1);
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TICK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_req,
  output logic              wdt_irq
);
  logic       mode_en, irq_status, reload, expire, irq_set;
  logic [3:0] mode_code, load_code;
  wd_action_e act;

  assign irq_set = expire && (act == ACT_IRQ);

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set),
    .mode_en(mode_en), .mode_code(mode_code), .act(act),
    .irq_status(irq_status), .reload(reload), .load_code(load_code)
  );

  wdog_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(mode_en), .reload(reload),
    .load_code(load_code), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= expire && (act == ACT_SYSRST);
  end

  assign wdt_irq = irq_status;
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sys_rst_req,
  input logic              wdt_irq,
  input logic              mode_en,
  input logic [3:0]        mode_code,
  input wd_action_e        act,
  input logic              expire,
  input logic              reload
);
  logic clr_wr, bad_mode_wr, bad_ctrl_wr;
  assign clr_wr      = bus_wr && (bus_addr == ADDR_W'(OFS_CFG)) &&
                       (bus_wdata[31:16] == WD_KEY) && bus_wdata[8];
  assign bad_mode_wr = bus_wr && (bus_addr == ADDR_W'(OFS_MODE)) && (bus_wdata[31:16] != WD_KEY);
  assign bad_ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && (bus_wdata[12:0] != 13'h14AF);

  assert_rst_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> ($past(act) == ACT_SYSRST) && $past(expire));
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_irq && !clr_wr) |=> wdt_irq);
  assert_irq_no_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (act == ACT_IRQ)) |=> !sys_rst_req);
  assert_bad_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode_wr |=> ($stable(mode_en) && $stable(mode_code)));
  assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !expire);
  assert_bad_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ctrl_wr |-> !reload);
endmodule

bind keyed_wdog wdog_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sys_rst_req(sys_rst_req), .wdt_irq(wdt_irq),
  .mode_en(mode_en), .mode_code(mode_code), .act(act),
  .expire(expire), .reload(reload)
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb;
  localparam int D = 8;
  localparam logic [31:0] K = 32'h16AA_0000;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic sys_rst_req, wdt_irq;
  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  bit done = 1'b0;

  keyed_wdog #(.ADDR_W(8), .TICK_DIV(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .wdt_irq(wdt_irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sys_rst_req) pulses <= pulses + 1;
  end

  // Period in clock cycles, stated as seconds-per-band arithmetic.
  function automatic int exp_cycles(input int code);
    int half;
    if (code == 0)       half = 1;
    else if (code <= 6)  half = 2 * code;
    else if (code <= 11) half = 4 * code - 12;
    else                 half = 32;
    return half * D;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int t);
    step();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
    t = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    step();
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_sig(input bit use_irq, output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      step();
      if (use_irq ? wdt_irq : sys_rst_req) begin
        at = cyc;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, t1, at, p0;
    int codes[8];
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk(sys_rst_req == 1'b0, "R10 rst_req", sys_rst_req, 0);
    chk(wdt_irq == 1'b0, "R10 irq", wdt_irq, 0);
    rd(8'h18, d); chk(d == 32'h0, "R10 mode", d, 0);
    rd(8'h14, d); chk(d == 32'h0, "R10 cfg", d, 0);
    rd(8'h10, d); chk(d == 32'h0, "R4 ctrl reads zero", d, 0);

    wr(8'h14, K | 32'h1, t0);
    rd(8'h14, d); chk(d == 32'h1, "R4 cfg readback", d, 1);

    // R5/R7 decode: directed band edges plus random codes
    codes[0] = 0; codes[1] = 7; codes[2] = 11; codes[3] = 15;
    for (int i = 4; i < 8; i++) codes[i] = int'($urandom % 16);
    foreach (codes[i]) begin
      wr(8'h18, K, t0);
      wr(8'h18, K | (32'(codes[i]) << 4) | 32'h1, t0);
      wait_sig(1'b0, at);
      chk(at - t0 == exp_cycles(codes[i]), "R5 first expiry", at - t0, exp_cycles(codes[i]));
      step();
      chk(sys_rst_req == 1'b0, "R7 one-cycle pulse", sys_rst_req, 0);
      t1 = at;
      wait_sig(1'b0, at);
      chk(at - t1 == exp_cycles(codes[i]), "R7 repeat expiry", at - t1, exp_cycles(codes[i]));
    end
    wr(8'h18, K, t0);

    // R4 mode readback, key field zero
    wr(8'h18, K | 32'h51, t0);
    rd(8'h18, d); chk(d == 32'h51, "R4 mode readback", d, 32'h51);
    wr(8'h18, K, t0);

    // R3 unkeyed writes ignored
    p0 = pulses;
    wr(8'h18, 32'h1234_0011, t0);
    rd(8'h18, d); chk(d == 32'h0, "R3 mode unkeyed", d, 0);
    repeat (100) step();
    chk(pulses == p0, "R3 no expiry after unkeyed enable", pulses - p0, 0);
    wr(8'h14, 32'h0000_0002, t0);
    rd(8'h14, d); chk(d == 32'h1, "R3 cfg unkeyed", d, 1);

    // R2 near-miss restarts leave schedule unchanged
    wr(8'h18, K | 32'h11, t0);
    repeat (4) step();
    wr(8'h10, 32'h0000_14AE, t1);
    wr(8'h10, 32'h0000_14CF, t1);
    wait_sig(1'b0, at);
    chk(at - t0 == exp_cycles(1), "R2 bad restart ignored", at - t0, exp_cycles(1));
    wr(8'h18, K, t0);

    // R1 exact restart reloads
    wr(8'h18, K | 32'h11, t0);
    repeat (6) step();
    wr(8'h10, 32'h0000_14AF, t1);
    wait_sig(1'b0, at);
    chk(at - t1 == exp_cycles(1), "R1 restart reload", at - t1, exp_cycles(1));
    wr(8'h18, K, t0);

    // R6 code change reloads
    wr(8'h18, K | 32'hB1, t0);
    repeat (20) step();
    wr(8'h18, K | 32'h11, t1);
    wait_sig(1'b0, at);
    chk(at - t1 == exp_cycles(1), "R6 code change reload", at - t1, exp_cycles(1));

    // R9 stop
    wr(8'h18, K | 32'h01, t0);
    wr(8'h18, K, t1);
    p0 = pulses;
    repeat (100) step();
    chk(pulses == p0, "R9 stopped no expiry", pulses - p0, 0);

    // R8 interrupt action
    wr(8'h14, K | 32'h2, t0);
    p0 = pulses;
    wr(8'h18, K | 32'h01, t0);
    wait_sig(1'b1, at);
    chk(at - t0 == exp_cycles(0), "R8 irq timing", at - t0, exp_cycles(0));
    repeat (30) step();
    chk(wdt_irq == 1'b1, "R8 irq sticky", wdt_irq, 1);
    chk(pulses == p0, "R8 no reset pulse", pulses - p0, 0);
    wr(8'h18, K, t0);
    rd(8'h14, d); chk(d == 32'h102, "R8 status readback", d, 32'h102);
    wr(8'h14, K | 32'h102, t0);
    rd(8'h14, d); chk(d == 32'h2, "R8 status cleared", d, 2);
    chk(wdt_irq == 1'b0, "R8 irq cleared", wdt_irq, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule